// File: doc/BRIEF.md
# Streaming Capture Packer with Block CRC

The block sits between a real-time sample source and the transmit FIFO of a serial slave port. Each accepted sample is appended to a left-aligned bit accumulator, and whole bytes are written to the FIFO as soon as they are complete. Samples are packed back to back with no padding, so a sample may straddle two or three bytes. A three-bit capture mode sets a decimation ratio that chooses which incoming samples are kept. The sample side never stalls. A sample that cannot be buffered is dropped and counted, and the count reaches the host as an in-band marker.

The byte stream is self-describing. The value 0xA5 is reserved as idle filler and is written whenever the serial side is starved while the port is selected. The value 0xA6 is reserved as an escape prefix. Payload bytes that collide with either reserved value are escaped, and overflow markers are built from the same prefix. Every non-filler, non-CRC byte is counted into a block. A 16-bit CRC follows each full block, and also follows each short block that is closed early. A block is closed early when slave select falls or the capture mode changes. Any residual bits are then flushed with zero padding, and the next block starts with a fresh CRC. Samples that arrive while a close or an overflow flush is in progress are counted as dropped.

Top module: `cap_packer`

## Requirements
- R1: Kept samples (SAMPLE_W bits, default 12) are packed MSB first into one continuous bit stream with no padding between them, and each completed byte is written to the FIFO, first bit in bit 7.
- R2: Capture mode m (0..7) keeps one sample in every 2^m valid samples. The first valid sample after reset or after a mode change is kept.
- R3: A packed byte equal to 0xA5 or 0xA6 is written as 0xA6 followed by the byte XOR 0x20 (0x85 or 0x86).
- R4: When slave select is active, the drain reports starvation and no other byte is due, 0xA5 is written. With slave select inactive, no filler is written.
- R5: A kept sample that does not fit in the accumulator is dropped and counted, saturating at 127. Once the buffered bits have been flushed (the last partial byte zero-padded), the marker 0xA6, 0x01, count is written. Samples arriving while drops are pending are also counted into that marker.
- R6: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, fed MSB first over every written byte except filler and CRC bytes. After each 256 such bytes, the CRC is written high byte first and the CRC is reset.
- R7: A falling edge of slave select, or a change of capture mode, flushes the residual bits zero-padded. It then closes the block with its CRC if the block holds any bytes, and the next block starts from 0xFFFF.
- R8: No write is issued while the FIFO reports full, and no byte is lost through a full FIFO.
- R9: During and after reset, with no stimulus, no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A sample is present this cycle |
| sampleData | input | SAMPLE_W | Sample value |
| captureMode | input | MODE_W | Decimation select, keeps one in 2^mode |
| ssActive | input | 1 | Slave select of the serial port, active high |
| drainStarved | input | 1 | Serial side wants a byte and the FIFO is empty |
| fifoFull | input | 1 | FIFO cannot take a byte this cycle |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | 8 | Byte written to the FIFO |

## Verification
The hardest situation to reach from the ports is the overflow marker, because it is emitted only after the buffered bits have drained. The stimulus holds the FIFO full while a burst of back-to-back samples overruns the 24-bit accumulator, then releases the FIFO. The exact byte order is then checked: data, marker, then CRC. A long burst confirms that the count saturates at 127. A separate long run keeps filler flowing between samples that include colliding byte values. An independent decoder in the bench strips filler, undoes escapes, checks every block CRC at its position, and rebuilds each sample.

// File: rtl/cap_pack_pkg.sv
package cap_pack_pkg;

  localparam logic [7:0] FILL_BYTE = 8'hA5;
  localparam logic [7:0] ESC_BYTE  = 8'hA6;
  localparam logic [7:0] MARK_TAG  = 8'h01;
  localparam logic [7:0] ESC_FLIP  = 8'h20;
  localparam logic [6:0] DROP_MAX  = 7'h7F;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CRC_HI, SEL_CRC_LO, SEL_TAIL, SEL_MARK_ESC,
    SEL_MARK_TAG, SEL_MARK_CNT, SEL_DATA, SEL_FILL
  } outSel_t;

  typedef struct packed {
    outSel_t sel;          // byte source chosen this cycle
    logic    fire;         // byte actually written
    logic    takeSample;   // append incoming sample
    logic    refuseSample; // kept sample lost
    logic    countByte;    // byte belongs to block payload
    logic    crcRestart;   // CRC back to seed
    logic    markLatch;    // freeze drop count into marker
  } strobe_t;

  function automatic logic [15:0] crcStep(logic [15:0] c, logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/cap_pack_dp.sv
module cap_pack_dp
  import cap_pack_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 24,
  localparam int CNT_W   = $clog2(ACC_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic [CNT_W-1:0]    accBits,
  output logic                dataSpecial,
  output logic                dropPending,
  output logic [7:0]          outByte
);

  logic [ACC_W-1:0] acc, accShift, sampleExt;
  logic [CNT_W-1:0] bitsAfter;
  logic [7:0]       dataByte, tailByte;
  logic [6:0]       dropCnt, markCnt, dropNext;
  logic [7:0]       dropSum;
  logic [15:0]      crc;
  logic             emitData;

  assign emitData    = stb.fire && (stb.sel == SEL_DATA);
  assign dataByte    = acc[ACC_W-1 -: 8];
  assign dataSpecial = (dataByte == FILL_BYTE) || (dataByte == ESC_BYTE);
  assign dropPending = (dropCnt != 7'd0);

  always_comb begin
    accShift  = emitData ? (acc << 8) : acc;
    bitsAfter = accBits;
    if (emitData) bitsAfter = (accBits >= CNT_W'(8)) ? accBits - CNT_W'(8) : '0;
    sampleExt = {sampleData, {(ACC_W-SAMPLE_W){1'b0}}} >> bitsAfter;
    dropSum   = {1'b0, dropCnt} + {7'd0, stb.refuseSample};
    dropNext  = (dropSum > {1'b0, DROP_MAX}) ? DROP_MAX : dropSum[6:0];
  end

  always_comb begin
    unique case (stb.sel)
      SEL_CRC_HI:   outByte = crc[15:8];
      SEL_CRC_LO:   outByte = crc[7:0];
      SEL_TAIL:     outByte = tailByte;
      SEL_MARK_ESC: outByte = ESC_BYTE;
      SEL_MARK_TAG: outByte = MARK_TAG;
      SEL_MARK_CNT: outByte = {1'b0, markCnt};
      SEL_DATA:     outByte = dataSpecial ? ESC_BYTE : dataByte;
      SEL_FILL:     outByte = FILL_BYTE;
      default:      outByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      accBits  <= '0;
      tailByte <= '0;
      dropCnt  <= '0;
      markCnt  <= '0;
      crc      <= 16'hFFFF;
    end else begin
      acc     <= stb.takeSample ? (accShift | sampleExt) : accShift;
      accBits <= bitsAfter + (stb.takeSample ? CNT_W'(SAMPLE_W) : '0);
      if (emitData) tailByte <= dataByte ^ ESC_FLIP;
      if (stb.markLatch) begin
        markCnt <= dropNext;
        dropCnt <= '0;
      end else begin
        dropCnt <= dropNext;
      end
      if (stb.crcRestart)     crc <= 16'hFFFF;
      else if (stb.countByte) crc <= crcStep(crc, outByte);
    end
  end

  p_acc_cap_r1: assert property (@(posedge clk) disable iff (!rstN)
    accBits <= CNT_W'(ACC_W));
  p_mark_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fire && stb.sel == SEL_MARK_ESC) |-> (accBits == '0));
  p_crc_seed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fire && stb.sel == SEL_CRC_LO) |=> (crc == 16'hFFFF));

endmodule

// File: rtl/cap_pack_ctrl.sv
module cap_pack_ctrl
  import cap_pack_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int ACC_W     = 24,
  parameter int BLOCK_LEN = 256,
  parameter int MODE_W    = 3,
  localparam int CNT_W    = $clog2(ACC_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [MODE_W-1:0] captureMode,
  input  logic              ssActive,
  input  logic              drainStarved,
  input  logic              fifoFull,
  input  logic [CNT_W-1:0]  accBits,
  input  logic              dataSpecial,
  input  logic              dropPending,
  output strobe_t           stb,
  output logic              wrEn
);

  localparam int BLK_W = $clog2(BLOCK_LEN);
  localparam int DEC_W = (1 << MODE_W) - 1;

  logic [1:0]        crcStage, markStage;
  logic              tailPend, closeReq, prevSs;
  logic [MODE_W-1:0] prevMode;
  logic [BLK_W-1:0]  blkCnt;
  logic [DEC_W-1:0]  decCnt, decMask;
  logic [DEC_W:0]    decWide;
  logic [CNT_W-1:0]  bitsAfter;
  logic modeChange, closeNow, flushing, blockDone, closeDone, keep, blocked, room;

  assign modeChange = (captureMode != prevMode);
  assign closeNow   = closeReq || modeChange || (prevSs && !ssActive);
  assign flushing   = closeNow || dropPending;
  assign decWide    = ({{DEC_W{1'b0}}, 1'b1} << captureMode) - 1'b1;
  assign decMask    = decWide[DEC_W-1:0];
  assign keep       = ((decCnt & decMask) == '0);

  always_comb begin
    stb = '0;
    stb.sel = SEL_NONE;
    if      (crcStage == 2'd1)  stb.sel = SEL_CRC_HI;
    else if (crcStage == 2'd2)  stb.sel = SEL_CRC_LO;
    else if (tailPend)          stb.sel = SEL_TAIL;
    else if (markStage == 2'd1) stb.sel = SEL_MARK_TAG;
    else if (markStage == 2'd2) stb.sel = SEL_MARK_CNT;
    else if (accBits >= CNT_W'(8) || (flushing && accBits != '0)) stb.sel = SEL_DATA;
    else if (dropPending)       stb.sel = SEL_MARK_ESC;
    else if (ssActive && drainStarved) stb.sel = SEL_FILL;
    stb.fire       = (stb.sel != SEL_NONE) && !fifoFull;
    stb.countByte  = stb.fire && !(stb.sel inside {SEL_CRC_HI, SEL_CRC_LO, SEL_FILL});
    stb.crcRestart = stb.fire && (stb.sel == SEL_CRC_LO);
    stb.markLatch  = stb.fire && (stb.sel == SEL_MARK_ESC);
    bitsAfter = accBits;
    if (stb.fire && stb.sel == SEL_DATA)
      bitsAfter = (accBits >= CNT_W'(8)) ? accBits - CNT_W'(8) : '0;
    room    = (int'(bitsAfter) + SAMPLE_W) <= ACC_W;
    blocked = closeNow || dropPending;
    stb.takeSample   = sampleValid && keep && !blocked && room;
    stb.refuseSample = sampleValid && keep && !stb.takeSample;
  end

  assign wrEn      = stb.fire;
  assign blockDone = stb.countByte && (blkCnt == BLK_W'(BLOCK_LEN - 1));
  assign closeDone = closeNow && crcStage == 2'd0 && !tailPend && markStage == 2'd0 &&
                     accBits == '0 && !stb.countByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcStage  <= '0;
      markStage <= '0;
      tailPend  <= 1'b0;
      closeReq  <= 1'b0;
      prevSs    <= 1'b0;
      prevMode  <= '0;
      blkCnt    <= '0;
      decCnt    <= '0;
    end else begin
      prevSs   <= ssActive;
      prevMode <= captureMode;
      closeReq <= closeNow && !closeDone;
      if (modeChange)       decCnt <= '0;
      else if (sampleValid) decCnt <= decCnt + 1'b1;
      if (stb.fire && stb.sel == SEL_CRC_HI)      crcStage <= 2'd2;
      else if (stb.fire && stb.sel == SEL_CRC_LO) crcStage <= 2'd0;
      else if (blockDone || (closeDone && blkCnt != '0)) crcStage <= 2'd1;
      if (blockDone || closeDone) blkCnt <= '0;
      else if (stb.countByte)     blkCnt <= blkCnt + 1'b1;
      if (stb.fire && stb.sel == SEL_DATA && dataSpecial) tailPend <= 1'b1;
      else if (stb.fire && stb.sel == SEL_TAIL)           tailPend <= 1'b0;
      if (stb.markLatch)                             markStage <= 2'd1;
      else if (stb.fire && stb.sel == SEL_MARK_TAG)  markStage <= 2'd2;
      else if (stb.fire && stb.sel == SEL_MARK_CNT)  markStage <= 2'd0;
    end
  end

  p_no_write_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !wrEn);
  p_filler_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && stb.sel == SEL_FILL) |-> (ssActive && drainStarved));
  p_crc_pair_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && stb.sel == SEL_CRC_HI) |=> (!wrEn || stb.sel == SEL_CRC_LO));
  p_tail_next_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && stb.sel == SEL_DATA && dataSpecial) |=>
      (!wrEn || stb.sel inside {SEL_TAIL, SEL_CRC_HI, SEL_CRC_LO}));

endmodule

// File: rtl/cap_packer.sv
module cap_packer
  import cap_pack_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int ACC_W     = 24,
  parameter int BLOCK_LEN = 256,
  parameter int MODE_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [MODE_W-1:0]   captureMode,
  input  logic                ssActive,
  input  logic                drainStarved,
  input  logic                fifoFull,
  output logic                fifoWrEn,
  output logic [7:0]          fifoWrData
);

  localparam int CNT_W = $clog2(ACC_W + 1);

  strobe_t          stb;
  logic [CNT_W-1:0] accBits;
  logic             dataSpecial, dropPending;

  cap_pack_ctrl #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .BLOCK_LEN(BLOCK_LEN), .MODE_W(MODE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .captureMode(captureMode),
    .ssActive(ssActive), .drainStarved(drainStarved), .fifoFull(fifoFull),
    .accBits(accBits), .dataSpecial(dataSpecial), .dropPending(dropPending),
    .stb(stb), .wrEn(fifoWrEn));

  cap_pack_dp #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .sampleData(sampleData),
    .accBits(accBits), .dataSpecial(dataSpecial), .dropPending(dropPending),
    .outByte(fifoWrData));

endmodule

// File: tb/sim_cap_packer.sv
`timescale 1ns/1ps
module sim_cap_packer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleData = '0;
  logic [2:0]  captureMode = '0;
  logic        ssActive = 1'b1;
  logic        drainStarved = 1'b0;
  logic        fifoFull = 1'b0;
  logic        fifoWrEn;
  logic [7:0]  fifoWrData;

  int checks = 0, failures = 0;
  int cap [0:2047];
  int capN = 0;
  int expB [0:63];
  int expN = 0;
  int dB [0:1023];
  int dN, marks, lastMark, fullBlocks;
  int sent [0:255];
  bit finished = 0;

  cap_packer u0 (.clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .captureMode(captureMode), .ssActive(ssActive), .drainStarved(drainStarved),
    .fifoFull(fifoFull), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData));

  always #5 clk = ~clk;

  always @(negedge clk)
    if (rstN && fifoWrEn && capN < 2048) begin
      cap[capN] = int'(fifoWrData);
      capN++;
    end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic sendOne(input int v, input int gap);
    sampleValid = 1'b1;
    sampleData = 12'(v);
    step();
    sampleValid = 1'b0;
    step(gap);
  endtask

  task automatic closeSs();
    drainStarved = 1'b0;
    ssActive = 1'b0;
    step(12);
    ssActive = 1'b1;
    step(2);
  endtask

  function automatic int crcBench(input int c, input int b);
    int r;
    r = c ^ (b << 8);
    for (int i = 0; i < 8; i++) begin
      if (r & 16'h8000) r = ((r << 1) ^ 16'h1021) & 16'hFFFF;
      else              r = (r << 1) & 16'hFFFF;
    end
    return r;
  endfunction

  // append CRC of current expected payload, then compare whole capture
  task automatic expectStream(input string req);
    int c;
    c = 16'hFFFF;
    for (int i = 0; i < expN; i++) c = crcBench(c, expB[i]);
    expB[expN] = c >> 8;
    expB[expN+1] = c & 8'hFF;
    expN += 2;
    chk(req, capN, expN);
    for (int i = 0; i < expN && i < capN; i++) chk(req, cap[i], expB[i]);
  endtask

  // independent host-side decoder
  task automatic decode();
    int c, counted, st, i;
    c = 16'hFFFF; counted = 0; st = 0; dN = 0; marks = 0; fullBlocks = 0; i = 0;
    while (i < capN - 2) begin
      if (counted == 256) begin
        chk("R6 block crc", (cap[i] << 8) | cap[i+1], c);
        fullBlocks++;
        i += 2; counted = 0; c = 16'hFFFF;
      end else begin
        if (!(cap[i] == 8'hA5)) begin
          c = crcBench(c, cap[i]);
          counted++;
          if (st == 0) begin
            if (cap[i] == 8'hA6) st = 1;
            else begin dB[dN] = cap[i]; dN++; end
          end else if (st == 1) begin
            if (cap[i] == 8'h01) st = 2;
            else begin dB[dN] = cap[i] ^ 8'h20; dN++; st = 0; end
          end else begin
            marks++; lastMark = cap[i]; st = 0;
          end
        end
        i++;
      end
    end
    chk("R6 closing crc", (cap[capN-2] << 8) | cap[capN-1], c);
  endtask

  function automatic int getSample(input int k);
    int v, bitPos;
    v = 0;
    for (int j = 0; j < 12; j++) begin
      bitPos = 12 * k + j;
      v = (v << 1) | ((dB[bitPos / 8] >> (7 - bitPos % 8)) & 1);
    end
    return v;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    step(3);
    chk("R9 write in reset", int'(fifoWrEn), 0);
    rstN = 1'b1;
    step(6);
    chk("R9 idle after reset", capN, 0);

    // R1 packing and R7 close on slave select fall
    capN = 0;
    sendOne(12'hABC, 3); sendOne(12'h123, 3); sendOne(12'h456, 3);
    chk("R1 bytes before close", capN, 4);
    closeSs();
    expN = 5;
    expB[0] = 8'hAB; expB[1] = 8'hC1; expB[2] = 8'h23; expB[3] = 8'h45; expB[4] = 8'h60;
    expectStream("R1 R7 packed stream");

    // R3 escaping of reserved values
    capN = 0;
    sendOne(12'hA5A, 3); sendOne(12'h6A5, 6);
    closeSs();
    expN = 6;
    expB[0] = 8'hA6; expB[1] = 8'h85; expB[2] = 8'hA6;
    expB[3] = 8'h86; expB[4] = 8'hA6; expB[5] = 8'h85;
    expectStream("R3 escape pairs");

    // R4 filler gating
    capN = 0;
    ssActive = 1'b0; drainStarved = 1'b1;
    step(5);
    chk("R4 no filler when deselected", capN, 0);
    ssActive = 1'b1;
    step(5);
    drainStarved = 1'b0;
    step(3);
    chk("R4 filler count", capN, 5);
    for (int i = 0; i < 5; i++) chk("R4 filler value", cap[i], 8'hA5);

    // R8 full FIFO blocks filler
    capN = 0;
    fifoFull = 1'b1; drainStarved = 1'b1;
    step(5);
    chk("R8 no write while full", capN, 0);
    drainStarved = 1'b0; fifoFull = 1'b0;
    step(2);

    // R5 overflow marker, count 4
    capN = 0;
    fifoFull = 1'b1;
    for (int i = 0; i < 6; i++) begin
      sampleValid = 1'b1;
      sampleData = (i == 0) ? 12'h111 : (i == 1) ? 12'h222 : 12'h777;
      step();
    end
    sampleValid = 1'b0;
    step(2);
    chk("R8 held while full", capN, 0);
    fifoFull = 1'b0;
    step(10);
    closeSs();
    expN = 6;
    expB[0] = 8'h11; expB[1] = 8'h12; expB[2] = 8'h22;
    expB[3] = 8'hA6; expB[4] = 8'h01; expB[5] = 8'h04;
    expectStream("R5 marker order");

    // R5 saturation at 127
    capN = 0;
    fifoFull = 1'b1;
    for (int i = 0; i < 132; i++) begin
      sampleValid = 1'b1;
      sampleData = (i == 0) ? 12'h111 : (i == 1) ? 12'h222 : 12'h333;
      step();
    end
    sampleValid = 1'b0;
    step(2);
    fifoFull = 1'b0;
    step(10);
    closeSs();
    expN = 6;
    expB[0] = 8'h11; expB[1] = 8'h12; expB[2] = 8'h22;
    expB[3] = 8'hA6; expB[4] = 8'h01; expB[5] = 8'h7F;
    expectStream("R5 saturated count");

    // R7 mode change flushes and closes
    capN = 0;
    sendOne(12'h9C3, 4);
    chk("R7 partial held", capN, 1);
    captureMode = 3'd1;
    step(10);
    expN = 2;
    expB[0] = 8'h9C; expB[1] = 8'h30;
    expectStream("R7 mode change close");

    // R2 decimation in mode 2
    captureMode = 3'd2;
    step(6);
    capN = 0;
    for (int i = 0; i < 12; i++) begin
      sent[i] = (i * 12'h2D3 + 12'h047) & 12'hFFF;
      sendOne(sent[i], 3);
    end
    closeSs();
    decode();
    chk("R2 kept byte count", dN, 5);
    for (int k = 0; k < 3; k++) chk("R2 kept sample", getSample(k), sent[4*k]);
    captureMode = 3'd0;
    step(6);

    // R6 long stream with filler and escapes, full-block CRC
    capN = 0;
    drainStarved = 1'b1;
    for (int i = 0; i < 200; i++) begin
      sent[i] = (i % 7 == 0) ? 12'hA5A : ((i * 1237 + 91) & 12'hFFF);
      sendOne(sent[i], 3);
    end
    step(8);
    closeSs();
    decode();
    chk("R6 full block seen", int'(fullBlocks >= 1), 1);
    chk("R5 no marker in clean run", marks, 0);
    chk("R1 long byte count", dN, 300);
    for (int k = 0; k < 200; k++) chk("R1 R3 rebuilt sample", getSample(k), sent[k]);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule